// File: doc/BRIEF.md
# Span Depth-Test Interpolator

This block fills one horizontal run of pixels on a scan line while removing hidden surfaces. A host hands over one span in a single ready/valid transfer. The transfer carries the row, the leftmost x, the span length, a starting depth and intensity, and the amount each of them changes from one pixel to the next. The block then walks the span from left to right. For each pixel it steps depth and intensity, fetches the depth already stored at that pixel, and compares the two. It writes new depth and intensity back only when the new surface is strictly nearer, which here means a smaller unsigned depth.

All arithmetic runs on a datapath one half-word wide. A 32-bit depth is handled as a low half and a high half, and a latched carry or borrow links the two half-operations. In full precision a pixel takes four cycles: two reads and two writes share those cycles with the two compare halves and the two step halves. A narrow mode treats depth and intensity as one half-word each and takes two cycles per pixel. The stored depth of the next pixel is fetched while the current pixel is still being compared. This overlap costs one extra pixel slot at the end of every span to drain the pipeline.

The FSM states are ST_IDLE, then the five load states ST_LD_CNT, ST_LD_Z, ST_LD_I, ST_LD_DZ and ST_LD_DI, then ST_FIRST (fetch only), ST_RUN (fetch, compare, write, step) and ST_FLUSH (compare and write only). The transitions are as follows:
- ST_IDLE moves to ST_LD_CNT when a load is accepted.
- Each load state moves to the next one unconditionally, and ST_LD_DI moves to ST_FIRST.
- ST_FIRST and ST_RUN move at the end of a slot to ST_RUN while the pixel down-counter is non-zero, and to ST_FLUSH when it is zero.
- ST_FLUSH returns to ST_IDLE at the end of its slot.

Top module: `span_zfill`

## Requirements
- R1: After reset, ld_ready is 1, span_done is 0, and neither mem_rd nor mem_wr is asserted.
- R2: A load is accepted only on a clock edge where ld_valid and ld_ready are both 1, and ld_ready is 1 exactly when the block is idle. A load offered while the block is busy has no effect on cycle timing or on memory contents.
- R3: After acceptance the block spends exactly five cycles on initialisation. Its first memory read is issued in the sixth cycle after the accepting edge.
- R4: In full mode (ld_narrow=0) a span of length L covers the L+1 pixels x = ld_x .. ld_x+L. It keeps ld_ready low for 5 + 4*(L+2) cycles, which includes one drain slot.
- R5: In narrow mode (ld_narrow=1) each pixel slot takes 2 cycles, so ld_ready stays low for 5 + 2*(L+2) cycles. Only the low half of depth and intensity is compared and written (mem_hi=0), and the high halves in memory stay unchanged.
- R6: Pixel k has depth ld_z + k*ld_dz modulo 2^32 (narrow: the low 16 bits). When this is unsigned-less than the stored depth, the block writes depth and intensity. When it is equal or greater, it writes nothing. A full-mode write puts the low half first and the high half in the next cycle.
- R7: Pixel k has intensity ld_i + k*ld_di at the same width as depth. It is written only together with a winning depth.
- R8: mem_addr is {row, x} with x = ld_x + k. mem_hi=1 selects the high half. Read data returns on mem_rz one cycle after mem_rd. A full-mode pixel reads its low half and then its high half on consecutive cycles.
- R9: span_done pulses for one cycle in the last busy cycle, and ld_ready is 1 in the following cycle.
- R10: A carry out of the low half during stepping reaches the high half. A borrow out of the low half during comparison decides the result when the high halves are equal.
- R11: mem_rd and mem_wr are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Span load offered |
| ld_ready | output | 1 | Block idle, load can be taken |
| ld_row | input | ROW_W | Scan-line row of the span |
| ld_x | input | X_W | Leftmost pixel x |
| ld_len | input | X_W | Rightmost x minus leftmost x |
| ld_z | input | 2*HALF_W | Depth at leftmost pixel |
| ld_i | input | 2*HALF_W | Intensity at leftmost pixel |
| ld_dz | input | 2*HALF_W | Depth change per pixel |
| ld_di | input | 2*HALF_W | Intensity change per pixel |
| ld_narrow | input | 1 | 1 selects half-word precision |
| mem_rd | output | 1 | Read stored depth half |
| mem_wr | output | 1 | Write depth and intensity half |
| mem_hi | output | 1 | Half select, 1 = high half |
| mem_addr | output | ROW_W+X_W | Pixel address {row, x} |
| mem_wz | output | HALF_W | Depth half to write |
| mem_wi | output | HALF_W | Intensity half to write |
| mem_rz | input | HALF_W | Stored depth half, one cycle after mem_rd |
| span_done | output | 1 | Last busy cycle of a span |

## Verification
The bench builds the block with HALF_W=16, X_W=4 and ROW_W=2. This gives a 64-pixel buffer that is compared entry by entry after every span. It also makes full-row spans with a length of 15, single-pixel spans, and a step whose low half wraps into the high half all reachable within a few spans. The half-word width is the real one, so carries and borrows between halves and the narrow mode's 16-bit wrap are exercised at their true boundaries.

// File: rtl/span_zfill_pkg.sv
package span_zfill_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LD_CNT,
        ST_LD_Z,
        ST_LD_I,
        ST_LD_DZ,
        ST_LD_DI,
        ST_FIRST,
        ST_RUN,
        ST_FLUSH
    } seq_state_e;

    // Per-cycle micro-operations of one pixel slot.
    typedef struct packed {
        logic rd;
        logic rd_hi;
        logic cmp;
        logic cmp_hi;
        logic cmp_last;
        logic cap;
        logic cap_hi;
        logic wr;
        logic wr_hi;
        logic step;
        logic step_hi;
        logic last;
    } slot_ops_t;

    localparam int WIDE_PHASES   = 4;
    localparam int NARROW_PHASES = 2;

    // Schedule of one pixel slot. Reads share the slot with the compare of
    // the previous pixel; writes and steps follow once the compare is known.
    function automatic slot_ops_t phase_ops(input logic narrow, input logic [1:0] ph);
        slot_ops_t o;
        o = '0;
        if (narrow) begin
            case (ph)
                2'd0: begin
                    o.rd = 1'b1; o.cmp = 1'b1; o.cmp_last = 1'b1;
                end
                default: begin
                    o.cap = 1'b1; o.wr = 1'b1; o.step = 1'b1; o.last = 1'b1;
                end
            endcase
        end else begin
            case (ph)
                2'd0: begin
                    o.rd = 1'b1; o.cmp = 1'b1;
                end
                2'd1: begin
                    o.rd = 1'b1; o.rd_hi = 1'b1;
                    o.cmp = 1'b1; o.cmp_hi = 1'b1; o.cmp_last = 1'b1;
                    o.cap = 1'b1;
                end
                2'd2: begin
                    o.cap = 1'b1; o.cap_hi = 1'b1;
                    o.wr = 1'b1; o.step = 1'b1;
                end
                default: begin
                    o.wr = 1'b1; o.wr_hi = 1'b1;
                    o.step = 1'b1; o.step_hi = 1'b1;
                    o.last = 1'b1;
                end
            endcase
        end
        return o;
    endfunction

endpackage

// File: rtl/span_lane.sv
// One interpolated quantity: a two-half accumulator stepped on a single
// half-width adder with a carry latch between the halves.
module span_lane #(
    parameter int HALF_W = 16,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_base,
    input  logic              ld_inc,
    input  logic [FULL_W-1:0] ld_val,
    input  logic              step,
    input  logic              step_hi,
    output logic [FULL_W-1:0] value
);

    logic [FULL_W-1:0] val_q;
    logic [FULL_W-1:0] inc_q;
    logic              carry_q;
    logic [HALF_W-1:0] a_half;
    logic [HALF_W-1:0] b_half;
    logic [HALF_W:0]   sum;

    always_comb begin
        a_half = step_hi ? val_q[FULL_W-1:HALF_W] : val_q[HALF_W-1:0];
        b_half = step_hi ? inc_q[FULL_W-1:HALF_W] : inc_q[HALF_W-1:0];
        sum    = {1'b0, a_half} + {1'b0, b_half}
               + {{HALF_W{1'b0}}, step_hi & carry_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q   <= '0;
            inc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            if (ld_base) begin
                val_q   <= ld_val;
                carry_q <= 1'b0;
            end
            if (ld_inc) begin
                inc_q <= ld_val;
            end
            if (step) begin
                carry_q <= sum[HALF_W];
                if (step_hi) begin
                    val_q[FULL_W-1:HALF_W] <= sum[HALF_W-1:0];
                end else begin
                    val_q[HALF_W-1:0] <= sum[HALF_W-1:0];
                end
            end
        end
    end

    assign value = val_q;

endmodule

// File: rtl/span_depth_cmp.sv
// Half-width subtractor that decides "new depth strictly nearer" over one or
// two half-operations, keeping the borrow between them.
module span_depth_cmp #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic              cmp_hi,
    input  logic              cmp_last,
    input  logic [HALF_W-1:0] new_half,
    input  logic [HALF_W-1:0] old_half,
    output logic              nearer
);

    logic            borrow_q;
    logic            nearer_q;
    logic            borrow_in;
    logic [HALF_W:0] diff;

    always_comb begin
        borrow_in = cmp_hi & borrow_q;
        diff      = {1'b0, new_half} - {1'b0, old_half}
                  - {{HALF_W{1'b0}}, borrow_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            borrow_q <= 1'b0;
            nearer_q <= 1'b0;
        end else if (cmp_en) begin
            borrow_q <= diff[HALF_W];
            if (cmp_last) begin
                nearer_q <= diff[HALF_W];
            end
        end
    end

    assign nearer = nearer_q;

endmodule

// File: rtl/span_seq.sv
// Span sequencer: load states, pixel slots, pixel down-counter, x position.
module span_seq
    import span_zfill_pkg::*;
#(
    parameter int X_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_fire,
    input  logic [X_W-1:0] ld_len,
    input  logic [X_W-1:0] ld_x,
    input  logic           ld_narrow,
    output seq_state_e     state,
    output slot_ops_t      ops,
    output logic [X_W-1:0] px,
    output logic           done
);

    localparam logic [X_W-1:0] X_ONE = {{(X_W-1){1'b0}}, 1'b1};

    seq_state_e     st_q;
    seq_state_e     st_d;
    logic [1:0]     ph_q;
    logic [X_W-1:0] cnt_q;
    logic [X_W-1:0] px_q;
    logic           narrow_q;
    slot_ops_t      raw;
    logic           in_slot;
    logic           fetching;
    logic           slot_end;

    assign raw      = phase_ops(narrow_q, ph_q);
    assign in_slot  = (st_q == ST_FIRST) || (st_q == ST_RUN) || (st_q == ST_FLUSH);
    assign fetching = (st_q == ST_FIRST) || (st_q == ST_RUN);
    assign slot_end = in_slot && raw.last;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (ld_fire) st_d = ST_LD_CNT;
            ST_LD_CNT: st_d = ST_LD_Z;
            ST_LD_Z:   st_d = ST_LD_I;
            ST_LD_I:   st_d = ST_LD_DZ;
            ST_LD_DZ:  st_d = ST_LD_DI;
            ST_LD_DI:  st_d = ST_FIRST;
            ST_FIRST,
            ST_RUN: begin
                if (slot_end) begin
                    st_d = (cnt_q == '0) ? ST_FLUSH : ST_RUN;
                end
            end
            ST_FLUSH:  if (slot_end) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Phase, counter and position registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= 2'd0;
            cnt_q    <= '0;
            px_q     <= '0;
            narrow_q <= 1'b0;
        end else begin
            if (!in_slot || raw.last) begin
                ph_q <= 2'd0;
            end else begin
                ph_q <= ph_q + 2'd1;
            end
            if (st_q == ST_LD_CNT) begin
                cnt_q    <= ld_len;
                px_q     <= ld_x;
                narrow_q <= ld_narrow;
            end else if (fetching && raw.last) begin
                px_q <= px_q + X_ONE;
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - X_ONE;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        ops = '0;
        unique case (st_q)
            ST_FIRST: begin
                ops.rd     = raw.rd;
                ops.rd_hi  = raw.rd_hi;
                ops.cap    = raw.cap;
                ops.cap_hi = raw.cap_hi;
                ops.last   = raw.last;
            end
            ST_RUN: begin
                ops = raw;
            end
            ST_FLUSH: begin
                ops         = raw;
                ops.rd      = 1'b0;
                ops.rd_hi   = 1'b0;
                ops.cap     = 1'b0;
                ops.cap_hi  = 1'b0;
                ops.step    = 1'b0;
                ops.step_hi = 1'b0;
            end
            default: ops = '0;
        endcase
    end

    assign state = st_q;
    assign px    = px_q;
    assign done  = (st_q == ST_FLUSH) && raw.last;

endmodule

// File: rtl/span_zfill.sv
module span_zfill
    import span_zfill_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int X_W    = 4,
    parameter int ROW_W  = 2,
    localparam int FULL_W = 2 * HALF_W,
    localparam int ADDR_W = ROW_W + X_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [ROW_W-1:0]  ld_row,
    input  logic [X_W-1:0]    ld_x,
    input  logic [X_W-1:0]    ld_len,
    input  logic [FULL_W-1:0] ld_z,
    input  logic [FULL_W-1:0] ld_i,
    input  logic [FULL_W-1:0] ld_dz,
    input  logic [FULL_W-1:0] ld_di,
    input  logic              ld_narrow,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_hi,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [HALF_W-1:0] mem_wz,
    output logic [HALF_W-1:0] mem_wi,
    input  logic [HALF_W-1:0] mem_rz,
    output logic              span_done
);

    localparam int LANES = 2;
    localparam logic [X_W-1:0] X_ONE = {{(X_W-1){1'b0}}, 1'b1};

    seq_state_e     st;
    slot_ops_t      ops;
    logic [X_W-1:0] px;
    logic           ld_fire;
    logic           nearer;

    // Span parameters held from acceptance until the span completes
    logic [ROW_W-1:0]  sh_row;
    logic [X_W-1:0]    sh_x;
    logic [X_W-1:0]    sh_len;
    logic [FULL_W-1:0] sh_z;
    logic [FULL_W-1:0] sh_i;
    logic [FULL_W-1:0] sh_dz;
    logic [FULL_W-1:0] sh_di;
    logic              sh_narrow;

    // Fetched stored depth: landing stage and compare stage
    logic [HALF_W-1:0] nxt_lo;
    logic [HALF_W-1:0] nxt_hi;
    logic [HALF_W-1:0] old_lo;
    logic [HALF_W-1:0] old_hi;

    logic [LANES-1:0]  lane_ld_base;
    logic [LANES-1:0]  lane_ld_inc;
    logic [FULL_W-1:0] lane_src [LANES];
    logic [FULL_W-1:0] lane_val [LANES];

    assign ld_ready = (st == ST_IDLE);
    assign ld_fire  = ld_valid && ld_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_row    <= '0;
            sh_x      <= '0;
            sh_len    <= '0;
            sh_z      <= '0;
            sh_i      <= '0;
            sh_dz     <= '0;
            sh_di     <= '0;
            sh_narrow <= 1'b0;
        end else if (ld_fire) begin
            sh_row    <= ld_row;
            sh_x      <= ld_x;
            sh_len    <= ld_len;
            sh_z      <= ld_z;
            sh_i      <= ld_i;
            sh_dz     <= ld_dz;
            sh_di     <= ld_di;
            sh_narrow <= ld_narrow;
        end
    end

    span_seq #(.X_W(X_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_fire   (ld_fire),
        .ld_len    (sh_len),
        .ld_x      (sh_x),
        .ld_narrow (sh_narrow),
        .state     (st),
        .ops       (ops),
        .px        (px),
        .done      (span_done)
    );

    // Lane 0 carries depth, lane 1 carries intensity.
    assign lane_ld_base = {st == ST_LD_I,  st == ST_LD_Z};
    assign lane_ld_inc  = {st == ST_LD_DI, st == ST_LD_DZ};
    assign lane_src[0]  = (st == ST_LD_Z) ? sh_z : sh_dz;
    assign lane_src[1]  = (st == ST_LD_I) ? sh_i : sh_di;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        span_lane #(.HALF_W(HALF_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_base (lane_ld_base[g]),
            .ld_inc  (lane_ld_inc[g]),
            .ld_val  (lane_src[g]),
            .step    (ops.step),
            .step_hi (ops.step_hi),
            .value   (lane_val[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_lo <= '0;
            nxt_hi <= '0;
            old_lo <= '0;
            old_hi <= '0;
        end else begin
            if (ops.cap) begin
                if (ops.cap_hi) begin
                    nxt_hi <= mem_rz;
                end else begin
                    nxt_lo <= mem_rz;
                end
            end
            if (ops.last) begin
                old_lo <= (ops.cap && !ops.cap_hi) ? mem_rz : nxt_lo;
                old_hi <= (ops.cap &&  ops.cap_hi) ? mem_rz : nxt_hi;
            end
        end
    end

    span_depth_cmp #(.HALF_W(HALF_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_en   (ops.cmp),
        .cmp_hi   (ops.cmp_hi),
        .cmp_last (ops.cmp_last),
        .new_half (ops.cmp_hi ? lane_val[0][FULL_W-1:HALF_W] : lane_val[0][HALF_W-1:0]),
        .old_half (ops.cmp_hi ? old_hi : old_lo),
        .nearer   (nearer)
    );

    // Memory port: reads address the pixel being fetched, writes the one before.
    assign mem_rd   = ops.rd;
    assign mem_wr   = ops.wr && nearer;
    assign mem_hi   = ops.rd ? ops.rd_hi : ops.wr_hi;
    assign mem_addr = {sh_row, ops.rd ? px : (px - X_ONE)};
    assign mem_wz   = ops.wr_hi ? lane_val[0][FULL_W-1:HALF_W] : lane_val[0][HALF_W-1:0];
    assign mem_wi   = ops.wr_hi ? lane_val[1][FULL_W-1:HALF_W] : lane_val[1][HALF_W-1:0];

endmodule

// File: rtl/span_zfill_chk.sv
module span_zfill_chk (
    input logic clk,
    input logic rst_n,
    input logic ld_valid,
    input logic ld_ready,
    input logic mem_rd,
    input logic mem_wr,
    input logic mem_hi,
    input logic span_done,
    input logic narrow
);

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ready |-> (!mem_rd && !mem_wr)); // R2

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready) |=> !ld_ready); // R2

    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        span_done |=> ld_ready); // R9

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        span_done |-> !ld_ready); // R9

    AST_NARROW_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ready && narrow && (mem_rd || mem_wr)) |-> !mem_hi); // R5

    AST_RD_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_hi) |-> $past(mem_rd && !mem_hi)); // R8

    AST_WR_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_hi) |-> $past(mem_wr && !mem_hi)); // R6

endmodule

bind span_zfill span_zfill_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_ready  (ld_ready),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_hi    (mem_hi),
    .span_done (span_done),
    .narrow    (sh_narrow)
);

// File: tb/span_zfill_test.sv
module span_zfill_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_W = 16;
    localparam int FULL_W = 32;
    localparam int X_W    = 4;
    localparam int ROW_W  = 2;
    localparam int ADDR_W = ROW_W + X_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int ROW_SZ = 1 << X_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_valid = 1'b0;
    logic              ld_ready;
    logic [ROW_W-1:0]  ld_row = '0;
    logic [X_W-1:0]    ld_x = '0;
    logic [X_W-1:0]    ld_len = '0;
    logic [FULL_W-1:0] ld_z = '0;
    logic [FULL_W-1:0] ld_i = '0;
    logic [FULL_W-1:0] ld_dz = '0;
    logic [FULL_W-1:0] ld_di = '0;
    logic              ld_narrow = 1'b0;
    logic              mem_rd;
    logic              mem_wr;
    logic              mem_hi;
    logic [ADDR_W-1:0] mem_addr;
    logic [HALF_W-1:0] mem_wz;
    logic [HALF_W-1:0] mem_wi;
    logic [HALF_W-1:0] mem_rz;
    logic              span_done;

    logic [FULL_W-1:0] mz [DEPTH];
    logic [FULL_W-1:0] mi [DEPTH];
    logic [FULL_W-1:0] ez [DEPTH];
    logic [FULL_W-1:0] ei [DEPTH];

    int n_chk  = 0;
    int n_fail = 0;

    span_zfill #(.HALF_W(HALF_W), .X_W(X_W), .ROW_W(ROW_W)) uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
        .ld_row(ld_row), .ld_x(ld_x), .ld_len(ld_len), .ld_z(ld_z), .ld_i(ld_i),
        .ld_dz(ld_dz), .ld_di(ld_di), .ld_narrow(ld_narrow),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_hi(mem_hi), .mem_addr(mem_addr),
        .mem_wz(mem_wz), .mem_wi(mem_wi), .mem_rz(mem_rz), .span_done(span_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [FULL_W-1:0] init_depth(input int a);
        int row;
        int x;
        row = a / ROW_SZ;
        x   = a % ROW_SZ;
        if (row == 2) return 32'h0001_8000 + 32'h0000_4000 * x;
        if (row == 3) return {16'hABCD, 16'h3000 + 16'h0800 * x[15:0]};
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [FULL_W-1:0] init_shade(input int a);
        return 32'h1111_0000 + a;
    endfunction

    // Depth/intensity memory with one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                mz[a] <= init_depth(a);
                mi[a] <= init_shade(a);
            end
            mem_rz <= '0;
        end else begin
            if (mem_rd) mem_rz <= mem_hi ? mz[mem_addr][31:16] : mz[mem_addr][15:0];
            if (mem_wr) begin
                if (mem_hi) begin
                    mz[mem_addr][31:16] <= mem_wz;
                    mi[mem_addr][31:16] <= mem_wi;
                end else begin
                    mz[mem_addr][15:0] <= mem_wz;
                    mi[mem_addr][15:0] <= mem_wi;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_span(input int row, input int xl, input int len,
                            input logic [31:0] z0, input logic [31:0] i0,
                            input logic [31:0] dz, input logic [31:0] di,
                            input bit nar, input bit poke, input string mtag);
        int busy;
        int first_rd;
        int wr_cyc;
        int wins;
        int a;
        logic [31:0] zk;
        logic [31:0] ik;
        busy = 5 + (len + 2) * (nar ? 2 : 4);
        wins = 0;
        for (int k = 0; k <= len; k++) begin
            a  = row * ROW_SZ + ((xl + k) % ROW_SZ);
            zk = z0 + dz * k;
            ik = i0 + di * k;
            if (nar) begin
                if (zk[15:0] < ez[a][15:0]) begin
                    ez[a][15:0] = zk[15:0];
                    ei[a][15:0] = ik[15:0];
                    wins++;
                end
            end else if (zk < ez[a]) begin
                ez[a] = zk;
                ei[a] = ik;
                wins++;
            end
        end

        @(negedge clk);
        check(ld_ready == 1'b1, "R2", "ready before load", ld_ready, 1);
        ld_row = row[ROW_W-1:0]; ld_x = xl[X_W-1:0]; ld_len = len[X_W-1:0];
        ld_z = z0; ld_i = i0; ld_dz = dz; ld_di = di; ld_narrow = nar;
        ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
        ld_row = ~ld_row; ld_x = ~ld_x; ld_len = ~ld_len;
        ld_z = 32'h0; ld_i = 32'h0; ld_dz = 32'h0; ld_di = 32'h0; ld_narrow = ~ld_narrow;
        first_rd = -1;
        wr_cyc   = 0;
        for (int c = 1; c <= busy + 1; c++) begin
            if (c > 1) @(negedge clk);
            if (c <= busy) begin
                check(ld_ready == 1'b0, nar ? "R5" : "R4", "ready while busy", ld_ready, 0);
                check(span_done == (c == busy), "R9", "done pulse", span_done, c == busy);
            end else begin
                check(ld_ready == 1'b1, "R9", "ready after done", ld_ready, 1);
                check(span_done == 1'b0, "R9", "done after span", span_done, 0);
            end
            check(!(mem_rd && mem_wr), "R11", "read and write together", {mem_rd, mem_wr}, 0);
            if (mem_rd && first_rd < 0) first_rd = c;
            if (mem_wr) wr_cyc++;
            if (poke && c == 2) ld_valid = 1'b1;
            if (poke && c == busy - 2) ld_valid = 1'b0;
        end
        check(first_rd == 6, "R3", "first read cycle", first_rd, 6);
        check(wr_cyc == (nar ? wins : 2 * wins), "R6", "write cycles", wr_cyc, nar ? wins : 2 * wins);
        for (int e = 0; e < DEPTH; e++) begin
            check(mz[e] == ez[e], mtag, $sformatf("depth at %0d", e), mz[e], ez[e]);
            check(mi[e] == ei[e], mtag, $sformatf("intensity at %0d", e), mi[e], ei[e]);
        end
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) begin
            ez[a] = init_depth(a);
            ei[a] = init_shade(a);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ld_ready == 1'b1, "R1", "ready after reset", ld_ready, 1);
        check(span_done == 1'b0, "R1", "done after reset", span_done, 0);
        check(mem_rd == 1'b0, "R1", "read after reset", mem_rd, 0);
        check(mem_wr == 1'b0, "R1", "write after reset", mem_wr, 0);

        // Span over far buffer: every pixel wins, low-half step carries (R10)
        run_span(1, 2, 5, 32'h0001_0000, 32'h0000_0100, 32'h0000_8000, 32'h0000_C000,
                 1'b0, 1'b0, "R6 R7 R8 R10");
        // Overlapping span with equal depths in the overlap (R6 equal -> no write)
        run_span(1, 0, 9, 32'h0000_0000, 32'h0200_0000, 32'h0000_8000, 32'h0000_0001,
                 1'b0, 1'b0, "R6 R7 R8");
        // Decreasing depth against a ramp, borrow across halves (R10)
        run_span(2, 1, 10, 32'h0002_0000, 32'h0300_0000, 32'hFFFF_C000, 32'h0001_0001,
                 1'b0, 1'b0, "R6 R7 R10");
        // Narrow mode over a full row, high halves must survive (R5)
        run_span(3, 0, 15, 32'h5555_3400, 32'h7777_0010, 32'h0000_0700, 32'h0000_0003,
                 1'b1, 1'b0, "R5 R6 R7");
        // Single-pixel spans at both row edges (R4, R5)
        run_span(0, 15, 0, 32'h0000_0042, 32'h0000_0007, 32'h0000_0001, 32'h0000_0001,
                 1'b0, 1'b0, "R4 R6 R8");
        run_span(0, 0, 0, 32'h0000_0043, 32'h0000_0009, 32'h0000_0001, 32'h0000_0001,
                 1'b1, 1'b0, "R5 R6 R8");
        // Load offered while busy is ignored (R2)
        run_span(0, 4, 3, 32'h0010_0000, 32'h0000_0500, 32'h0000_1000, 32'h0000_0010,
                 1'b0, 1'b1, "R2 R6 R7");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule